// File: doc/BRIEF.md
# Memory-Write Packet Transmit Framer

This block turns transmit descriptors into memory-write transaction-layer packets and sends them out as a stream of 32-bit doublewords, one per accepted beat, under a valid/ready handshake. Each descriptor is 64 bits wide. The low word is the target address. One bit of the high word selects the direction: transmit or receive. A receive descriptor is accepted and dropped. A transmit descriptor makes one packet.

A packet is a three-doubleword header, then the payload, then an optional end-to-end CRC word. The header carries the requester identity, traffic class, attributes, payload length and the CRC-present flag. These values come from a small bank of configuration registers that a plain write port updates. The descriptor supplies only the address. Payload doublewords are read from a local buffer through a synchronous read port that behaves like a block RAM. The CRC is accumulated while the packet is sent, and the block stalls cleanly when the link side withholds ready.

Top module: `tlp_tx_framer`

## Requirements
- R1: After reset, `tx_valid` is low and `desc_ready` is high.
- R2: Bit 32 of a descriptor selects its direction: 1 is transmit and gets framed, 0 is receive. A receive descriptor is accepted and produces no beats. It leaves the packet tag unchanged, and all other upper bits are ignored.
- R3: A transmit packet is sent in this order: three header doublewords, then the payload words for buffer indices 0 to len-1 in ascending order, then the CRC word if CRC is enabled. `tx_last` is high on the final beat only.
- R4: Header word 0 has this layout: [31:29]=3'b010, [28:24]=5'b00000, [22:20]=traffic class, bit 15 = CRC enable, [13:12]=attributes, [9:0]=payload length. Every other bit is zero.
- R5: Header word 1 has this layout: [31:16]=requester ID, [15:8]=tag, [7:4]=4'hF when length > 1 and 4'h0 otherwise, [3:0]=4'hF.
- R6: The tag starts at 0 after reset. It goes up by one for each framed packet and wraps from 255 to 0.
- R7: Header word 2 is descriptor bits [31:2] followed by two zero bits.
- R8: The configured length is an 8-bit field. A value of 0 gives a length of 1, and a value above 16 gives 16.
- R9: The CRC word is the bitwise inverse of a CRC-32 register. The register uses polynomial 0x04C11DB7 and seed 0xFFFFFFFF. It is fed MSB first over every header and payload word, with bits 24 and 14 of header word 0 taken as ones.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values and `tx_valid` stays high.
- R11: `desc_ready` stays low from the acceptance of a transmit descriptor until the final beat of its packet is taken.
- R12: Configuration is captured when a descriptor is accepted. Register writes made during a packet affect only later packets.
- R13: Each payload word is fetched with one pulse of `buf_rd_en` and its index on `buf_rd_addr`. The buffer returns the word on `buf_rd_data` in the cycle after the pulse and holds it until the next pulse.
- R14: Configuration writes: address 0 sets the requester ID from bits [15:0]. Address 1 sets traffic class from [2:0], attributes from [5:4] and CRC enable from bit 8. Address 2 sets the raw length from [7:0]. Reset values are 0, 0, 0, disabled and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_data | input | 64 | Descriptor: address in [31:0], direction in bit 32 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| buf_rd_en | output | 1 | Payload buffer read pulse |
| buf_rd_addr | output | 4 | Payload word index |
| buf_rd_data | input | 32 | Payload word, valid the cycle after the read pulse |
| tx_valid | output | 1 | Output beat valid |
| tx_ready | input | 1 | Link side accepts the beat |
| tx_data | output | 32 | Output doubleword |
| tx_last | output | 1 | Final beat of the packet |

## Verification
The assertions check on every cycle that a stalled beat stays frozen and that the beat after a final beat is idle. They also check that the first header word carries the memory-write format and type, that buffer reads stay inside the captured length, and that the captured length stays within 1 to 16.

Only the bench scenarios can show the rest. These are the full header contents, payload order, CRC values, tag sequence and wrap, dropping of receive descriptors, and clamping of lengths 0 and 20. They also include the snapshot behaviour when configuration is rewritten in the middle of a packet. A behavioural model predicts each beat, and random backpressure is applied while the beats are checked.

// File: rtl/tlp_tx_pkg.sv
package tlp_tx_pkg;

  localparam logic [2:0]  FMT_WR3 = 3'b010;
  localparam logic [4:0]  TYPE_MEM = 5'b00000;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam logic [31:0] VARIANT_MASK = 32'h0100_4000;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR0, S_HDR1, S_HDR2, S_PAY, S_CRC
  } fr_state_t;

  typedef struct packed {
    logic [15:0] rid;
    logic [2:0]  tc;
    logic [1:0]  attr;
    logic        crc_en;
    logic [7:0]  len_raw;
  } fr_cfg_t;

  function automatic logic [31:0] crc32_word(input logic [31:0] c_in,
                                             input logic [31:0] d);
    logic [31:0] c;
    c = c_in;
    for (int i = 31; i >= 0; i--) begin
      if (c[31] ^ d[i]) c = (c << 1) ^ CRC_POLY;
      else              c = c << 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/tlp_cfg_bank.sv
module tlp_cfg_bank
  import tlp_tx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [31:0]   wdata,
  output fr_cfg_t       cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.rid     <= '0;
      cfg.tc      <= '0;
      cfg.attr    <= '0;
      cfg.crc_en  <= 1'b0;
      cfg.len_raw <= 8'd1;
    end else if (we) begin
      case (addr)
        2'd0: cfg.rid <= wdata[15:0];
        2'd1: begin
          cfg.tc     <= wdata[2:0];
          cfg.attr   <= wdata[5:4];
          cfg.crc_en <= wdata[8];
        end
        2'd2: cfg.len_raw <= wdata[7:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tlp_crc_acc.sv
module tlp_crc_acc
  import tlp_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        restart,
  input  logic        en,
  input  logic [31:0] word,
  output logic [31:0] crc_q
);
  logic [31:0] base;
  assign base = restart ? CRC_SEED : crc_q;

  always_ff @(posedge clk) begin
    if (rst)          crc_q <= CRC_SEED;
    else if (en)      crc_q <= crc32_word(base, word);
    else if (restart) crc_q <= CRC_SEED;
  end
endmodule

// File: rtl/tlp_tx_framer.sv
module tlp_tx_framer
  import tlp_tx_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int DIR_BIT = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        desc_valid,
  output logic                        desc_ready,
  input  logic [63:0]                 desc_data,
  input  logic                        cfg_we,
  input  logic [1:0]                  cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  output logic                        buf_rd_en,
  output logic [$clog2(MAX_LEN)-1:0]  buf_rd_addr,
  input  logic [31:0]                 buf_rd_data,
  output logic                        tx_valid,
  input  logic                        tx_ready,
  output logic [31:0]                 tx_data,
  output logic                        tx_last
);
  localparam int IDX_W = $clog2(MAX_LEN);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  fr_cfg_t     cfg;
  fr_state_t   st;
  logic [31:0] addr_q;
  logic [15:0] rid_q;
  logic [2:0]  tc_q;
  logic [1:0]  attr_q;
  logic        crc_en_q;
  logic [LEN_W-1:0] len_q, len_norm;
  logic [IDX_W-1:0] len_m1, cnt;
  logic [7:0]  tag;
  logic        data_ok;
  logic [31:0] crc_q;

  logic        out_free, load, load_last;
  logic [31:0] load_word, dw0, dw1, dw2, crc_in;

  tlp_cfg_bank u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .cfg(cfg)
  );

  always_comb begin
    if (cfg.len_raw == 8'd0)                 len_norm = LEN_W'(1);
    else if (cfg.len_raw > 8'(MAX_LEN))      len_norm = LEN_W'(MAX_LEN);
    else                                     len_norm = LEN_W'(cfg.len_raw);
  end

  assign len_m1 = IDX_W'(len_q - LEN_W'(1));
  assign dw0 = {FMT_WR3, TYPE_MEM, 1'b0, tc_q, 4'b0, crc_en_q, 1'b0, attr_q, 2'b0, 10'(len_q)};
  assign dw1 = {rid_q, tag, (len_q > LEN_W'(1)) ? 4'hF : 4'h0, 4'hF};
  assign dw2 = {addr_q[31:2], 2'b00};

  assign out_free   = !tx_valid || tx_ready;
  assign desc_ready = (st == S_IDLE) && !tx_valid;

  always_comb begin
    load = 1'b0;
    load_word = '0;
    load_last = 1'b0;
    case (st)
      S_HDR0: begin load = out_free; load_word = dw0; end
      S_HDR1: begin load = out_free; load_word = dw1; end
      S_HDR2: begin load = out_free; load_word = dw2; end
      S_PAY: begin
        load = out_free && data_ok;
        load_word = buf_rd_data;
        load_last = (cnt == len_m1) && !crc_en_q;
      end
      S_CRC: begin load = out_free; load_word = ~crc_q; load_last = 1'b1; end
      default: ;
    endcase
  end

  assign crc_in = (st == S_HDR0) ? (load_word | VARIANT_MASK) : load_word;

  tlp_crc_acc u_crc (
    .clk(clk), .rst(rst), .restart(st == S_HDR0),
    .en(load && (st != S_CRC)), .word(crc_in), .crc_q(crc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      tx_valid <= 1'b0;
      tx_data <= '0;
      tx_last <= 1'b0;
      tag <= '0;
      buf_rd_en <= 1'b0;
      buf_rd_addr <= '0;
      data_ok <= 1'b0;
      cnt <= '0;
      addr_q <= '0;
      rid_q <= '0;
      tc_q <= '0;
      attr_q <= '0;
      crc_en_q <= 1'b0;
      len_q <= LEN_W'(1);
    end else begin
      buf_rd_en <= 1'b0;
      data_ok <= buf_rd_en | (data_ok & !(load && st == S_PAY));
      if (load) begin
        tx_valid <= 1'b1;
        tx_data <= load_word;
        tx_last <= load_last;
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
      case (st)
        S_IDLE: if (desc_valid && desc_ready && desc_data[DIR_BIT]) begin
          addr_q <= desc_data[31:0];
          rid_q <= cfg.rid;
          tc_q <= cfg.tc;
          attr_q <= cfg.attr;
          crc_en_q <= cfg.crc_en;
          len_q <= len_norm;
          st <= S_HDR0;
        end
        S_HDR0: if (load) st <= S_HDR1;
        S_HDR1: if (load) st <= S_HDR2;
        S_HDR2: if (load) begin
          st <= S_PAY;
          cnt <= '0;
          buf_rd_en <= 1'b1;
          buf_rd_addr <= '0;
        end
        S_PAY: if (load) begin
          if (cnt == len_m1) begin
            st <= crc_en_q ? S_CRC : S_IDLE;
            if (!crc_en_q) tag <= tag + 8'd1;
          end else begin
            cnt <= cnt + IDX_W'(1);
            buf_rd_en <= 1'b1;
            buf_rd_addr <= cnt + IDX_W'(1);
          end
        end
        S_CRC: if (load) begin
          st <= S_IDLE;
          tag <= tag + 8'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: a beat offered but not taken stays frozen
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R3: nothing follows the final beat directly
  a_r3_quiet_after_last: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);

  // R4: first header word carries the write format and memory type
  a_r4_first_word_kind: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && st == S_HDR1) |-> (tx_data[31:24] == 8'h40));

  // R13: reads stay within the captured length
  a_r13_read_in_range: assert property (@(posedge clk) disable iff (rst)
    buf_rd_en |-> (buf_rd_addr <= len_m1));

  // R8: captured length is within range
  a_r8_len_range: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |-> (len_q >= LEN_W'(1) && len_q <= LEN_W'(MAX_LEN)));

endmodule

// File: tb/tlp_tx_framer_tb_top.sv
module tlp_tx_framer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [63:0] desc_data = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        buf_rd_en;
  logic [3:0]  buf_rd_addr;
  logic [31:0] buf_rd_data = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        tx_last;

  always #2.5 clk = ~clk;

  tlp_tx_framer dut_i (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_data(desc_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
  );

  int vecs = 0;
  int errs = 0;
  int cycles = 0;
  int stall_pct = 0;
  int acc_cnt = 0;
  logic [31:0] mem [16];
  logic [32:0] expq [$];
  logic [15:0] m_rid = '0;
  logic [2:0]  m_tc = '0;
  logic [1:0]  m_attr = '0;
  logic        m_crc = 1'b0;
  logic [7:0]  m_len = 8'd1;
  logic [7:0]  m_tag = '0;
  logic        prev_v = 1'b0, prev_r = 1'b0, prev_l = 1'b0;
  logic [31:0] prev_d = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_ref(input logic [31:0] c_in, input logic [31:0] d);
    logic [31:0] c = c_in;
    for (int b = 31; b >= 0; b--) begin
      logic fb = c[31] ^ d[b];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  // behavioural model of one accepted descriptor
  function automatic void model_accept(input logic [63:0] d);
    int len;
    logic [31:0] w0, w1, w2, c;
    if (!d[32]) return;  // R2: receive descriptors drop
    len = (m_len == 0) ? 1 : (m_len > 16) ? 16 : int'(m_len);  // R8
    w0 = {3'b010, 5'b00000, 1'b0, m_tc, 4'b0, m_crc, 1'b0, m_attr, 2'b0, 10'(len)};
    w1 = {m_rid, m_tag, (len > 1) ? 4'hF : 4'h0, 4'hF};
    w2 = {d[31:2], 2'b00};
    c = crc_ref(32'hFFFFFFFF, w0 | 32'h01004000);
    c = crc_ref(c, w1);
    c = crc_ref(c, w2);
    expq.push_back({1'b0, w0});
    expq.push_back({1'b0, w1});
    expq.push_back({1'b0, w2});
    for (int i = 0; i < len; i++) begin
      c = crc_ref(c, mem[i]);
      expq.push_back({(!m_crc && i == len - 1), mem[i]});
    end
    if (m_crc) expq.push_back({1'b1, ~c});
    m_tag = m_tag + 8'd1;
  endfunction

  always @(posedge clk) if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      logic r;
      r = (($urandom % 100) >= stall_pct);
      tx_ready = r;
      if (prev_v && !prev_r)
        chk(tx_valid && tx_data == prev_d && tx_last == prev_l, "R10 hold",
            {31'b0, tx_valid, tx_data}, {31'b0, 1'b1, prev_d});
      if (tx_valid && r) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R2/R3 unexpected beat", {31'b0, tx_last, tx_data}, '0);
        end else begin
          logic [32:0] e;
          e = expq.pop_front();
          chk({tx_last, tx_data} == e, "R3/R4/R5/R6/R7/R9 beat",
              {31'b0, tx_last, tx_data}, {31'b0, e});
        end
      end
      if (expq.size() > 0)
        chk(!desc_ready, "R11 busy", {63'b0, desc_ready}, 64'd0);
      if (desc_valid && desc_ready) begin
        acc_cnt++;
        model_accept(desc_data);
      end
      prev_v = tx_valid; prev_r = r; prev_d = tx_data; prev_l = tx_last;
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] w);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = w;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    case (a)  // R14 register map
      2'd0: m_rid = w[15:0];
      2'd1: begin m_tc = w[2:0]; m_attr = w[5:4]; m_crc = w[8]; end
      2'd2: m_len = w[7:0];
      default: ;
    endcase
  endtask

  task automatic send(input logic [63:0] d);
    int start;
    start = acc_cnt;
    @(posedge clk); #1;
    desc_valid = 1'b1; desc_data = d;
    while (acc_cnt == start) @(posedge clk);
    #1 desc_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((expq.size() != 0 || tx_valid) && n < 5000) begin @(posedge clk); n++; end
    chk(expq.size() == 0, "R3 drain", 64'(expq.size()), 64'd0);
  endtask

  task automatic fill_mem(input int salt);
    for (int i = 0; i < 16; i++) mem[i] = {8'(salt), 8'(i), 16'($urandom)};
  endtask

  initial begin
    fill_mem(1);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!tx_valid && desc_ready, "R1 reset", {62'b0, tx_valid, desc_ready}, 64'd1);

    // R4 R5 R7 R14 basic packet, no CRC, unaligned address
    cfg_write(2'd0, 32'h0000_BEEF);
    cfg_write(2'd1, 32'h0000_0025);
    cfg_write(2'd2, 32'd4);
    send({32'h1, 32'h1234_5677});
    drain();

    // R9 CRC with single word (last BE zero) under backpressure
    stall_pct = 40;
    fill_mem(2);
    cfg_write(2'd1, 32'h0000_0113);
    cfg_write(2'd2, 32'd1);
    send({32'h1, 32'hCAFE_0008});
    drain();

    // R8 length boundaries
    stall_pct = 50;
    cfg_write(2'd2, 32'd0);
    send({32'h1, 32'h0000_1000});
    cfg_write(2'd2, 32'd16);
    send({32'h1, 32'h0000_2003});
    drain();
    fill_mem(3);
    cfg_write(2'd2, 32'd20);
    cfg_write(2'd1, 32'h0000_0007);
    send({32'h1, 32'h0000_3001});
    drain();

    // R2 receive descriptors are dropped; tag unchanged
    send({32'hFFFF_FFFE, 32'hDEAD_BEEF});
    send({32'h0, 32'h0000_4000});
    repeat (20) @(posedge clk);
    chk(expq.size() == 0 && !tx_valid, "R2 drop", {63'b0, tx_valid}, 64'd0);
    cfg_write(2'd2, 32'd3);
    send({32'h8000_0001, 32'h0000_5004});
    drain();

    // R12 config rewritten mid-packet
    stall_pct = 90;
    cfg_write(2'd2, 32'd8);
    cfg_write(2'd1, 32'h0000_0134);
    send({32'h1, 32'h0000_6000});
    cfg_write(2'd2, 32'd2);
    cfg_write(2'd0, 32'h0000_1357);
    cfg_write(2'd1, 32'h0000_0000);
    drain();
    stall_pct = 20;
    send({32'h1, 32'h0000_7000});
    drain();

    // R6 tag wrap across 256 packets
    stall_pct = 0;
    cfg_write(2'd2, 32'd1);
    for (int k = 0; k < 258; k++) send({32'h1, 32'(k * 4)});
    drain();

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    while (cycles < 150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule